// File: doc/BRIEF.md
# Load Stream and Stride Prefetcher

This block observes a flow of loads, each presented as the address of the load instruction and the byte address it reads, and turns regular access patterns into cache-line prefetch requests. It combines two detectors. A stream detector keeps the line numbers of the most recent loads and fires when a new load lands on the line directly above one of them; it then asks for the line after the current one. A stride predictor keeps a small direct-mapped table indexed by the low bits of the instruction address; each entry learns the distance between consecutive addresses of that one instruction and, once that distance has repeated, asks for the line holding the next predicted address. Strides in either direction are followed.

Both detectors refuse targets that leave the 4 KB page of the current load, and the stride predictor ignores strides whose magnitude exceeds half a page. Requests leave through a single-entry output register with a valid/ready handshake carrying a line number. A request that is not yet accepted is held unchanged, and new candidates that appear meanwhile are dropped. Cache lookup, duplicate filtering and fills are handled elsewhere.

Top module: `pf_top`

## Requirements
- R1: After reset `reqValid` is 0, the stride table holds no valid entries and the recent-line history is empty.
- R2: A line number is the byte address shifted right by LINE_BITS (6 by default, 64-byte lines). When a load is accepted (`ldValid` high at a clock edge) and its line minus one equals one of the lines of the last STREAM_DEPTH accepted loads, a request for its line plus one is presented with `reqValid` high after that same edge.
- R3: A stream request whose target line lies in a different 4 KB page (byte address bits above bit 11) than the load is not issued.
- R4: The stride table is indexed by `ldPc` bits [IDX_W-1:0] and tagged by the remaining upper bits; for a hit, the stride is the load address minus the stored last address, and a qualifying hit requests the line of load address plus stride.
- R5: Negative strides (load address below the stored last address) are predicted in the same way as positive ones.
- R6: Confidence is 0 on allocation and whenever the stride changes, increments (saturating at 3) when the stride repeats; a stride request is issued only when the updated confidence is 2 or more and the stride is nonzero, so a constant stride first prefetches on the fourth load of that instruction.
- R7: A stride whose magnitude is at most 2048 bytes may be prefetched; a larger magnitude is never prefetched.
- R8: A stride target in a different 4 KB page than the load is not issued.
- R9: When both detectors produce a candidate for the same load, the stride target is requested and the stream target is dropped.
- R10: While `reqValid` is high and `reqReady` is low, `reqValid` and `reqLine` stay unchanged and candidates from loads in those cycles are discarded.
- R11: A load whose tag differs from the valid entry at its index replaces that entry with its own tag, its address, stride 0 and confidence 0, and issues no stride request.
- R12: When the output is free (not valid, or accepted in that cycle) and an accepted load yields no candidate, `reqValid` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | A load is presented this cycle |
| ldPc | input | PC_W | Instruction address of the load |
| ldAddr | input | ADDR_W | Byte address read by the load |
| reqValid | output | 1 | A prefetch request is offered |
| reqReady | input | 1 | The consumer accepts the offered request |
| reqLine | output | ADDR_W-LINE_BITS | Line number to prefetch |

## Verification
Every result of this block is due exactly one clock edge after the load that causes it: the table, the history and the output register are all written at the edge that samples the load, so a request for load N is visible right after that edge, and a held request under back-pressure must still be there after each later edge. The bench drives a load and the ready level at the falling edge, lets the rising edge pass, advances its own model of table, history and output register from the same inputs, and compares `reqValid` and `reqLine` one time unit later. Directed sequences place the fourth load of a trained stride, the page edge, the 2048-byte cap, a same-load collision of both detectors and an index alias at known cycles, and a long seeded random run covers mixed patterns and random ready.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadOut;    // write the output line register
    logic takeStride; // choose the stride target over the stream target
  } pfStrobe_t;
endpackage

// File: rtl/pf_datapath.sv
module pf_datapath
  import pf_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PC_W         = 32,
  parameter int LINE_BITS    = 6,
  parameter int PAGE_BITS    = 12,
  parameter int ENTRIES      = 16,
  parameter int STREAM_DEPTH = 4,
  parameter int MAX_STRIDE   = 2048
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ldValid,
  input  logic [PC_W-1:0]             ldPc,
  input  logic [ADDR_W-1:0]           ldAddr,
  input  pfStrobe_t                   strobe,
  output logic                        strideFire,
  output logic                        streamFire,
  output logic [ADDR_W-LINE_BITS-1:0] reqLine
);
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int TAG_W    = PC_W - IDX_W;
  localparam int LINE_W   = ADDR_W - LINE_BITS;
  localparam int PG_LINE  = PAGE_BITS - LINE_BITS;

  // stride table
  logic              entValid  [ENTRIES];
  logic [TAG_W-1:0]  entTag    [ENTRIES];
  logic [ADDR_W-1:0] entLast   [ENTRIES];
  logic [ADDR_W-1:0] entStride [ENTRIES];
  logic [1:0]        entConf   [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, sameStride;
  logic [ADDR_W-1:0] newStride, strideAbs, strideTarget;
  logic [1:0]        confNext;
  logic [LINE_W-1:0] strideLine;

  assign idx        = ldPc[IDX_W-1:0];
  assign tag        = ldPc[PC_W-1:IDX_W];
  assign hit        = entValid[idx] && (entTag[idx] == tag);
  assign newStride  = ldAddr - entLast[idx];
  assign sameStride = (newStride == entStride[idx]);
  assign strideAbs  = newStride[ADDR_W-1] ? (~newStride + ADDR_W'(1)) : newStride;
  assign strideTarget = ldAddr + newStride;
  assign strideLine = strideTarget[ADDR_W-1:LINE_BITS];

  always_comb begin
    if (!hit || !sameStride) confNext = 2'd0;
    else if (entConf[idx] == 2'd3) confNext = 2'd3;
    else confNext = entConf[idx] + 2'd1;
  end

  assign strideFire = ldValid && hit && sameStride && (newStride != '0) &&
                      (confNext >= 2'd2) && (strideAbs <= ADDR_W'(MAX_STRIDE)) &&
                      (strideTarget[ADDR_W-1:PAGE_BITS] == ldAddr[ADDR_W-1:PAGE_BITS]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        entValid[i]  <= 1'b0;
        entTag[i]    <= '0;
        entLast[i]   <= '0;
        entStride[i] <= '0;
        entConf[i]   <= 2'd0;
      end
    end else if (ldValid) begin
      entValid[idx] <= 1'b1;
      entTag[idx]   <= tag;
      entLast[idx]  <= ldAddr;
      entStride[idx] <= hit ? newStride : '0;
      entConf[idx]  <= confNext;
    end
  end

  // recent-line history for the stream detector
  logic [LINE_W-1:0] histLine  [STREAM_DEPTH];
  logic              histValid [STREAM_DEPTH];
  logic [STREAM_DEPTH-1:0] histMatch;
  logic [LINE_W-1:0] curLine, prevLine, streamLine;

  assign curLine    = ldAddr[ADDR_W-1:LINE_BITS];
  assign prevLine   = curLine - LINE_W'(1);
  assign streamLine = curLine + LINE_W'(1);

  for (genvar g = 0; g < STREAM_DEPTH; g++) begin : g_hist
    assign histMatch[g] = histValid[g] && (histLine[g] == prevLine);
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          histValid[g] <= 1'b0;
          histLine[g]  <= '0;
        end else if (ldValid) begin
          histValid[g] <= 1'b1;
          histLine[g]  <= curLine;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          histValid[g] <= 1'b0;
          histLine[g]  <= '0;
        end else if (ldValid) begin
          histValid[g] <= histValid[g-1];
          histLine[g]  <= histLine[g-1];
        end
      end
    end
  end

  assign streamFire = ldValid && (|histMatch) &&
                      (streamLine[LINE_W-1:PG_LINE] == curLine[LINE_W-1:PG_LINE]);

  // output line register
  always_ff @(posedge clk) begin
    if (!rst_n) reqLine <= '0;
    else if (strobe.loadOut) reqLine <= strobe.takeStride ? strideLine : streamLine;
  end

  // R9: a stride candidate taken into the output wins over the stream target
  p_stride_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadOut && strideFire) |=> (reqLine == $past(strideLine)));
endmodule

// File: rtl/pf_control.sv
module pf_control
  import pf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strideFire,
  input  logic      streamFire,
  input  logic      reqReady,
  output logic      reqValid,
  output pfStrobe_t strobe
);
  logic busy;
  assign busy = reqValid && !reqReady;

  always_comb begin
    strobe.loadOut    = !busy && (strideFire || streamFire);
    strobe.takeStride = strideFire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reqValid <= 1'b0;
    else if (strobe.loadOut) reqValid <= 1'b1;
    else if (!busy) reqValid <= 1'b0;
  end

  // R10: an unaccepted request stays offered
  p_hold_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqReady) |=> reqValid);
endmodule

// File: rtl/pf_top.sv
module pf_top
  import pf_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PC_W         = 32,
  parameter int LINE_BITS    = 6,
  parameter int PAGE_BITS    = 12,
  parameter int ENTRIES      = 16,
  parameter int STREAM_DEPTH = 4,
  parameter int MAX_STRIDE   = 2048
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ldValid,
  input  logic [PC_W-1:0]             ldPc,
  input  logic [ADDR_W-1:0]           ldAddr,
  output logic                        reqValid,
  input  logic                        reqReady,
  output logic [ADDR_W-LINE_BITS-1:0] reqLine
);
  localparam int PG_LINE = PAGE_BITS - LINE_BITS;
  localparam int LINE_W  = ADDR_W - LINE_BITS;

  pfStrobe_t strobe;
  logic strideFire, streamFire;

  pf_datapath #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS),
    .ENTRIES(ENTRIES), .STREAM_DEPTH(STREAM_DEPTH), .MAX_STRIDE(MAX_STRIDE)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .ldValid(ldValid), .ldPc(ldPc), .ldAddr(ldAddr),
    .strobe(strobe), .strideFire(strideFire), .streamFire(streamFire),
    .reqLine(reqLine)
  );

  pf_control ctl_i (
    .clk(clk), .rst_n(rst_n), .strideFire(strideFire), .streamFire(streamFire),
    .reqReady(reqReady), .reqValid(reqValid), .strobe(strobe)
  );

  // R10: the offered line does not move while waiting for ready
  p_hold_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqReady) |=> $stable(reqLine));

  // R2: a new request only follows an accepted load
  p_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !$past(reqValid)) |-> $past(ldValid));

  // R8 (and R3): a freshly loaded request stays in the page of its load
  p_same_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !$past(reqValid && !reqReady)) |->
      (reqLine[LINE_W-1:PG_LINE] == $past(ldAddr[ADDR_W-1:PAGE_BITS])));
endmodule

// File: tb/pf_top_tb_top.sv
module pf_top_tb_top;
  localparam int ADDR_W = 32, PC_W = 32, LINE_BITS = 6, ENTRIES = 16, DEPTH = 4;
  localparam int LINE_W = ADDR_W - LINE_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ldValid = 1'b0;
  logic [PC_W-1:0] ldPc = '0;
  logic [ADDR_W-1:0] ldAddr = '0;
  logic reqReady = 1'b1;
  logic reqValid;
  logic [LINE_W-1:0] reqLine;

  always #5 clk = ~clk;

  pf_top dut_i (
    .clk(clk), .rst_n(rst_n), .ldValid(ldValid), .ldPc(ldPc), .ldAddr(ldAddr),
    .reqValid(reqValid), .reqReady(reqReady), .reqLine(reqLine)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // reference state
  bit          mValid  [ENTRIES];
  logic [27:0] mTag    [ENTRIES];
  logic [31:0] mLast   [ENTRIES];
  logic [31:0] mStride [ENTRIES];
  int          mConf   [ENTRIES];
  bit          hValid  [DEPTH];
  logic [LINE_W-1:0] hLine [DEPTH];
  bit          expValid;
  logic [LINE_W-1:0] expLine;

  function automatic bit samePage(logic [31:0] a, logic [31:0] b);
    return a[31:12] == b[31:12];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < ENTRIES; i++) begin
      mValid[i] = 0; mTag[i] = '0; mLast[i] = '0; mStride[i] = '0; mConf[i] = 0;
    end
    for (int i = 0; i < DEPTH; i++) begin hValid[i] = 0; hLine[i] = '0; end
    expValid = 0; expLine = '0;
  endtask

  task automatic modelStep(bit v, logic [31:0] pc, logic [31:0] a, bit rdy);
    bit sFire = 0, qFire = 0;
    logic [LINE_W-1:0] sLine = '0, qLine = '0, cl;
    if (v) begin
      int ix = int'(pc[3:0]);
      bit h = mValid[ix] && (mTag[ix] == pc[31:4]);
      logic [31:0] d = a - mLast[ix];
      int sd = int'(d);
      int mag = (sd < 0) ? -sd : sd;
      int cn;
      logic [31:0] tgt = a + d;
      if (h && d == mStride[ix]) cn = (mConf[ix] == 3) ? 3 : mConf[ix] + 1;
      else cn = 0;
      if (h && d == mStride[ix] && d != 0 && cn >= 2 && mag <= 2048 && samePage(tgt, a)) begin
        sFire = 1; sLine = tgt[31:6];
      end
      mValid[ix] = 1; mTag[ix] = pc[31:4]; mLast[ix] = a;
      mStride[ix] = h ? d : '0; mConf[ix] = cn;
      cl = a[31:6];
      for (int i = 0; i < DEPTH; i++)
        if (hValid[i] && hLine[i] == cl - 1) qFire = 1;
      qLine = cl + 1;
      if (qLine[LINE_W-1:6] != cl[LINE_W-1:6]) qFire = 0;
      for (int i = DEPTH - 1; i > 0; i--) begin hValid[i] = hValid[i-1]; hLine[i] = hLine[i-1]; end
      hValid[0] = 1; hLine[0] = cl;
    end
    if (expValid && !rdy) begin
      // hold
    end else if (sFire) begin expValid = 1; expLine = sLine; end
    else if (qFire) begin expValid = 1; expLine = qLine; end
    else expValid = 0;
  endtask

  task automatic compare(string tag);
    nChecks++;
    if (reqValid !== expValid || (expValid && reqLine !== expLine)) begin
      nFails++;
      $display("FAIL %s: reqValid=%0b reqLine=%h expected reqValid=%0b reqLine=%h",
               tag, reqValid, reqLine, expValid, expLine);
    end
  endtask

  task automatic step(bit v, logic [31:0] pc, logic [31:0] a, bit rdy, string tag);
    @(negedge clk);
    ldValid = v; ldPc = pc; ldAddr = a; reqReady = rdy;
    @(posedge clk);
    #1;
    modelStep(v, pc, a, rdy);
    compare(tag);
  endtask

  task automatic load(logic [31:0] pc, logic [31:0] a, string tag);
    step(1, pc, a, 1, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  logic [31:0] rPc [8];
  logic [31:0] rCur [8];
  logic [31:0] rStr [8];
  logic [31:0] strideSet [8];

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: idle after reset
    step(0, 0, 0, 1, "R1 reset");
    step(0, 0, 0, 0, "R1 reset");

    // R2: ascending lines
    load(32'h101, 32'h0001_0000, "R2 stream");
    load(32'h101, 32'h0001_0040, "R2 stream");
    load(32'h102, 32'h0001_0080, "R2 stream");
    // R3: next line would leave the page
    load(32'h103, 32'h0002_0F80, "R3 page");
    load(32'h103, 32'h0002_0FC0, "R3 page");
    // R4 R6: positive stride, first request on the fourth load
    for (int k = 0; k < 6; k++) load(32'h204, 32'h0003_0000 + k * 32'h100, "R4 R6 stride");
    // R5: negative stride
    for (int k = 0; k < 6; k++) load(32'h205, 32'h0004_8000 - k * 32'h200, "R5 negative");
    // R7: stride above the cap, then exactly at the cap
    for (int k = 0; k < 5; k++) load(32'h306, 32'h0006_0600 + k * 32'h900, "R7 cap above");
    for (int k = 0; k < 4; k++) load(32'h307, 32'h0007_0900 + k * 32'h800, "R7 cap equal");
    // R8: stride target across a page
    for (int k = 0; k < 6; k++) load(32'h408, 32'h0008_0C00 + k * 32'h100, "R8 page");
    // R9: both detectors on one load
    load(32'h509, 32'h0009_0000, "R9 priority");
    load(32'h509, 32'h0009_0080, "R9 priority");
    load(32'h509, 32'h0009_0100, "R9 priority");
    load(32'h50A, 32'h0009_0140, "R9 priority");
    load(32'h509, 32'h0009_0180, "R9 priority");
    // R10: back-pressure holds and drops
    load(32'h60B, 32'h000A_0000, "R10 hold");
    step(1, 32'h60B, 32'h000A_0040, 0, "R10 hold");
    step(1, 32'h60C, 32'h000A_0080, 0, "R10 hold");
    step(1, 32'h60C, 32'h000A_00C0, 0, "R10 hold");
    step(0, 0, 0, 0, "R10 hold");
    step(0, 0, 0, 1, "R10 hold");
    step(0, 0, 0, 1, "R12 release");
    // R11: two instruction addresses alias on one index
    for (int k = 0; k < 3; k++) load(32'h00D, 32'h000B_0000 + k * 32'h100, "R11 alias");
    load(32'h10D, 32'h000C_0000, "R11 alias");
    load(32'h00D, 32'h000B_0300, "R11 alias");
    for (int k = 4; k < 8; k++) load(32'h00D, 32'h000B_0000 + k * 32'h100, "R11 alias");

    // R12 plus mixed random traffic
    strideSet[0] = 32'h40;  strideSet[1] = 32'h80;  strideSet[2] = -32'sd256;
    strideSet[3] = 32'hC0;  strideSet[4] = 32'h800; strideSet[5] = -32'sd64;
    strideSet[6] = 32'h900; strideSet[7] = 32'h10;
    for (int i = 0; i < 8; i++) begin
      rPc[i]  = {$urandom_range(0, 3) == 0 ? 24'h0 : 24'($urandom), 4'($urandom_range(0, 15)), 4'h0} >> 4;
      rCur[i] = $urandom & 32'h00FF_FFC0;
      rStr[i] = strideSet[$urandom_range(0, 7)];
    end
    for (int n = 0; n < 4000; n++) begin
      int p = $urandom_range(0, 7);
      bit v = ($urandom_range(0, 9) < 8);
      bit rdy = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) rCur[p] = $urandom & 32'h00FF_FFFC;
      else rCur[p] = rCur[p] + rStr[p];
      if ($urandom_range(0, 63) == 0) rStr[p] = strideSet[$urandom_range(0, 7)];
      step(v, rPc[p], rCur[p], rdy, "R12 random");
    end
    step(0, 0, 0, 1, "R12 drain");
    step(0, 0, 0, 1, "R12 drain");
    summary();
  end
endmodule